// File: doc/BRIEF.md
# Address-Space Decode and Cache Control Register Stage

This block sits between the processor's data port and the cache and translation subsystem. Every data access carries an 8-bit address-space identifier next to its address, direction and write data. The stage classifies the access by that identifier. It then does one of four things:
- steers the access to a downstream target with a one-hot select strobe (normal cached access, forced miss, tag or data diagnostics of either cache, or the translation-unit registers);
- serves it locally from the register file;
- turns it into a cache flush;
- rejects it with an error response.

The register file holds the writable control register. Its fields give a mode for each cache, the snoop enable and the instruction burst-fill enable. The register file also presents one read-only configuration word per cache, built from parameters. Two bits of the control register, and two dedicated identifiers, are flush triggers rather than storage. Each produces a single-cycle flush pulse, and the trigger bits always read back as zero. A separate flush-instruction input pulses both flushes at once.

The control state machine records the class of the access accepted at each clock edge, and every response comes one cycle after the request. The states are:
- `ST_IDLE`: no access was accepted.
- `ST_ROUTE`: the access was forwarded.
- `ST_REGRD`: a register was read.
- `ST_REGWR`: a register was written.
- `ST_FLUSH`: a flush identifier was written.
- `ST_FAULT`: the access was not decoded.

From any state, the next state is chosen by the class of the incoming request. With no request present, the next state is `ST_IDLE`. A new request may be accepted every cycle.

Top module: `asi_ctl_top`

## Requirements
- R1: Identifiers 0x08, 0x09, 0x0A and 0x0B raise select bit 0 (normal cached access), and identifier 0x01 raises select bit 1 (forced miss). The select strobe comes one cycle after the request, with rsp_valid high and rsp_err low.
- R2: Identifiers 0x0C, 0x0D, 0x0E and 0x0F raise select bits 2, 3, 4 and 5 (instruction tag, instruction data, data tag, data data). Identifier 0x19 raises select bit 6 (translation registers) for any address.
- R3: A write with identifier 0x02 and address low byte 0x00 stores the control register. Bit 23 drives snoop_en, bit 16 drives burst_en, bits 3:2 drive dc_mode and bits 1:0 drive ic_mode. A read of that register returns these fields in place, with every other bit zero. The mode outputs change only when such a write occurs.
- R4: Writing 1 to control bit 22 pulses flush_dc, and writing 1 to control bit 21 pulses flush_ic. Each pulse is high for exactly the cycle after the write. Both bits always read as zero.
- R5: Any write with identifier 0x15 pulses flush_ic, and any write with identifier 0x16 pulses flush_dc, whatever the address or data. Neither raises a select bit.
- R6: A one-cycle flush_all input pulses both flush_ic and flush_dc in the following cycle, without a response.
- R7: Reads with identifier 0x02 return the instruction cache configuration at address low byte 0x08 and the data cache configuration at 0x0C. The configuration layout is:
  - bit 31: lock supported
  - bits 29:28: replacement code
  - bit 27: snoop supported
  - bits 26:24: ways minus one
  - bits 23:20: log2 of way size in KB
  - bit 19: local RAM present
  - bits 18:16: log2 of line words
  - bits 15:12: log2 of local RAM KB
  - bits 11:4: local RAM base address bits 31:24
  - bit 3: translation unit present

  Writes to either configuration word respond without error and change nothing.
- R8: An identifier not listed above, an identifier-0x02 access at any other address low byte, or a read with identifier 0x15 or 0x16, returns rsp_err high. Such an access raises no select bit, gives zero read data and leaves the control register unchanged.
- R9: After reset, rsp_valid, rsp_err, every select bit and both flush pulses are low, and the control register and every mode output are zero.
- R10: When a select bit is raised, fwd_addr, fwd_wdata and fwd_write hold the address, data and direction of that access.
- R11: Requests on consecutive cycles each receive their own response in the cycle after them. rsp_valid is low in any cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_asi | input | 8 | Address-space identifier |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| flush_all | input | 1 | Flush-instruction indication, flushes both caches |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_err | output | 1 | Access was not decoded |
| rsp_rdata | output | 32 | Register read data, zero otherwise |
| tgt_sel | output | 7 | One-hot downstream select, bit order as in R1/R2 |
| fwd_addr | output | 32 | Address of the forwarded access |
| fwd_wdata | output | 32 | Write data of the forwarded access |
| fwd_write | output | 1 | Direction of the forwarded access |
| flush_ic | output | 1 | Instruction cache flush pulse |
| flush_dc | output | 1 | Data cache flush pulse |
| ic_mode | output | 2 | Instruction cache mode field |
| dc_mode | output | 2 | Data cache mode field |
| snoop_en | output | 1 | Data cache snoop enable |
| burst_en | output | 1 | Instruction burst-fill enable |

## Verification
The identifier space is swept completely, once as reads and once as writes. This separates the routed classes, the register class, the flush class and the error class, and it exposes any identifier that is mis-steered or wrongly accepted. A sweep of all 256 address low bytes under identifier 0x02 separates the three real registers from the reserved offsets. Control writes use the all-ones pattern and the two alternating bit patterns, so that each field and each flush trigger is seen set alone and together. Back-to-back routed requests, the flush_all pulse, and writes to the configuration words and to undecoded identifiers, each followed by a read-back, show that every response belongs to its own request and that the ignored accesses left the state untouched.

// File: rtl/asi_ctl_pkg.sv
`timescale 1ns/1ps
package asi_ctl_pkg;

    localparam int N_TGT = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ROUTE, ST_REGRD, ST_REGWR, ST_FLUSH, ST_FAULT
    } ctl_state_e;

    typedef enum logic [2:0] {
        TG_CACHE = 3'd0, TG_MISS = 3'd1, TG_ITAG = 3'd2, TG_IDATA = 3'd3,
        TG_DTAG = 3'd4, TG_DDATA = 3'd5, TG_MMU = 3'd6
    } tgt_e;

    typedef enum logic [1:0] { RG_CTRL, RG_ICFG, RG_DCFG } reg_e;

    localparam logic [7:0] ID_MISS  = 8'h01;
    localparam logic [7:0] ID_SYS   = 8'h02;
    localparam logic [7:0] ID_IFLSH = 8'h15;
    localparam logic [7:0] ID_DFLSH = 8'h16;
    localparam logic [7:0] ID_XLAT  = 8'h19;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_ICFG = 8'h08;
    localparam logic [7:0] OFS_DCFG = 8'h0C;

    localparam int B_SNOOP = 23;
    localparam int B_FLD   = 22;
    localparam int B_FLI   = 21;
    localparam int B_BURST = 16;

    typedef struct packed {
        ctl_state_e kind;
        tgt_e       tgt;
        reg_e       rsel;
        logic       fl_i;
        logic       fl_d;
    } dec_t;

    function automatic logic [31:0] cfg_pack(
        input int lock, input int repl, input int snoop, input int ways,
        input int set_log2, input int lram, input int line_log2,
        input int lram_log2, input int lram_base, input int xlat);
        logic [2:0] wm1;
        wm1 = 3'(ways - 1);
        return {1'(lock), 1'b0, 2'(repl), 1'(snoop), wm1, 4'(set_log2),
                1'(lram), 3'(line_log2), 4'(lram_log2), 8'(lram_base),
                1'(xlat), 3'b000};
    endfunction

endpackage

// File: rtl/asi_classify.sv
`timescale 1ns/1ps
module asi_classify
    import asi_ctl_pkg::*;
#(
    parameter int ASI_W = 8,
    parameter int OFS_W = 8
) (
    input  logic             valid,
    input  logic [ASI_W-1:0] asi,
    input  logic [OFS_W-1:0] ofs,
    input  logic             write,
    output dec_t             dec
);
    always_comb begin
        dec = '{kind: ST_IDLE, tgt: TG_CACHE, rsel: RG_CTRL, fl_i: 1'b0, fl_d: 1'b0};
        if (valid) begin
            dec.kind = ST_ROUTE;
            case (asi)
                8'h08, 8'h09, 8'h0A, 8'h0B: dec.tgt = TG_CACHE;
                ID_MISS:  dec.tgt = TG_MISS;
                8'h0C:    dec.tgt = TG_ITAG;
                8'h0D:    dec.tgt = TG_IDATA;
                8'h0E:    dec.tgt = TG_DTAG;
                8'h0F:    dec.tgt = TG_DDATA;
                ID_XLAT:  dec.tgt = TG_MMU;
                ID_SYS: begin
                    dec.kind = write ? ST_REGWR : ST_REGRD;
                    case (ofs)
                        OFS_CTRL: dec.rsel = RG_CTRL;
                        OFS_ICFG: dec.rsel = RG_ICFG;
                        OFS_DCFG: dec.rsel = RG_DCFG;
                        default:  dec.kind = ST_FAULT;
                    endcase
                end
                ID_IFLSH: begin
                    dec.kind = write ? ST_FLUSH : ST_FAULT;
                    dec.fl_i = write;
                end
                ID_DFLSH: begin
                    dec.kind = write ? ST_FLUSH : ST_FAULT;
                    dec.fl_d = write;
                end
                default: dec.kind = ST_FAULT;
            endcase
        end
    end
endmodule

// File: rtl/asi_ctl_reg.sv
`timescale 1ns/1ps
module asi_ctl_reg
    import asi_ctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              id_fl_i,
    input  logic              id_fl_d,
    input  logic              flush_all,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [1:0]        ic_mode,
    output logic [1:0]        dc_mode,
    output logic              snoop_en,
    output logic              burst_en,
    output logic              flush_ic,
    output logic              flush_dc
);
    logic snoop_q, burst_q;
    logic [1:0] icm_q, dcm_q;
    logic fi_d, fd_d;

    assign fi_d = flush_all | id_fl_i | (wr_en & wdata[B_FLI]);
    assign fd_d = flush_all | id_fl_d | (wr_en & wdata[B_FLD]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snoop_q  <= 1'b0;
            burst_q  <= 1'b0;
            icm_q    <= 2'b00;
            dcm_q    <= 2'b00;
            flush_ic <= 1'b0;
            flush_dc <= 1'b0;
        end else begin
            flush_ic <= fi_d;
            flush_dc <= fd_d;
            if (wr_en) begin
                snoop_q <= wdata[B_SNOOP];
                burst_q <= wdata[B_BURST];
                dcm_q   <= wdata[3:2];
                icm_q   <= wdata[1:0];
            end
        end
    end

    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[B_SNOOP] = snoop_q;
        ctrl_rd[B_BURST] = burst_q;
        ctrl_rd[3:2]     = dcm_q;
        ctrl_rd[1:0]     = icm_q;
    end

    assign ic_mode  = icm_q;
    assign dc_mode  = dcm_q;
    assign snoop_en = snoop_q;
    assign burst_en = burst_q;
endmodule

// File: rtl/asi_cfg_word.sv
`timescale 1ns/1ps
module asi_cfg_word
    import asi_ctl_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LOCK      = 0,
    parameter int REPL      = 0,
    parameter int SNOOP     = 0,
    parameter int WAYS      = 1,
    parameter int SET_LOG2  = 0,
    parameter int LRAM      = 0,
    parameter int LINE_LOG2 = 2,
    parameter int LRAM_LOG2 = 0,
    parameter int LRAM_BASE = 0,
    parameter int XLAT      = 0
) (
    output logic [DATA_W-1:0] word
);
    localparam logic [31:0] PACKED = cfg_pack(LOCK, REPL, SNOOP, WAYS, SET_LOG2,
                                              LRAM, LINE_LOG2, LRAM_LOG2,
                                              LRAM_BASE, XLAT);
    assign word = DATA_W'(PACKED);
endmodule

// File: rtl/asi_ctl_top.sv
`timescale 1ns/1ps
module asi_ctl_top
    import asi_ctl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int ASI_W       = 8,
    parameter int OFS_W       = 8,
    parameter int I_LOCK      = 1,
    parameter int I_REPL      = 1,
    parameter int I_WAYS      = 2,
    parameter int I_SET_LOG2  = 2,
    parameter int I_LINE_LOG2 = 3,
    parameter int I_LRAM      = 0,
    parameter int I_LRAM_LOG2 = 0,
    parameter int I_LRAM_BASE = 0,
    parameter int D_LOCK      = 0,
    parameter int D_REPL      = 3,
    parameter int D_SNOOP     = 1,
    parameter int D_WAYS      = 4,
    parameter int D_SET_LOG2  = 4,
    parameter int D_LINE_LOG2 = 2,
    parameter int D_LRAM      = 1,
    parameter int D_LRAM_LOG2 = 3,
    parameter int D_LRAM_BASE = 142,
    parameter int XLAT        = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ASI_W-1:0]  req_asi,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              flush_all,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [N_TGT-1:0]  tgt_sel,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic              fwd_write,
    output logic              flush_ic,
    output logic              flush_dc,
    output logic [1:0]        ic_mode,
    output logic [1:0]        dc_mode,
    output logic              snoop_en,
    output logic              burst_en
);
    localparam int N_CACHE = 2;

    dec_t              dec;
    ctl_state_e        state;
    tgt_e              tgt_q;
    reg_e              rsel_q;
    logic [DATA_W-1:0] ctrl_rd;
    logic [DATA_W-1:0] cfg_w [N_CACHE];

    asi_classify #(.ASI_W(ASI_W), .OFS_W(OFS_W)) u_cls (
        .valid (req_valid),
        .asi   (req_asi),
        .ofs   (req_addr[OFS_W-1:0]),
        .write (req_write),
        .dec   (dec)
    );

    asi_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dec.kind == ST_REGWR && dec.rsel == RG_CTRL),
        .wdata     (req_wdata),
        .id_fl_i   (dec.fl_i),
        .id_fl_d   (dec.fl_d),
        .flush_all (flush_all),
        .ctrl_rd   (ctrl_rd),
        .ic_mode   (ic_mode),
        .dc_mode   (dc_mode),
        .snoop_en  (snoop_en),
        .burst_en  (burst_en),
        .flush_ic  (flush_ic),
        .flush_dc  (flush_dc)
    );

    for (genvar g = 0; g < N_CACHE; g++) begin : g_cfg
        asi_cfg_word #(
            .DATA_W    (DATA_W),
            .LOCK      (g == 0 ? I_LOCK      : D_LOCK),
            .REPL      (g == 0 ? I_REPL      : D_REPL),
            .SNOOP     (g == 0 ? 0           : D_SNOOP),
            .WAYS      (g == 0 ? I_WAYS      : D_WAYS),
            .SET_LOG2  (g == 0 ? I_SET_LOG2  : D_SET_LOG2),
            .LRAM      (g == 0 ? I_LRAM      : D_LRAM),
            .LINE_LOG2 (g == 0 ? I_LINE_LOG2 : D_LINE_LOG2),
            .LRAM_LOG2 (g == 0 ? I_LRAM_LOG2 : D_LRAM_LOG2),
            .LRAM_BASE (g == 0 ? I_LRAM_BASE : D_LRAM_BASE),
            .XLAT      (XLAT)
        ) u_word (
            .word (cfg_w[g])
        );
    end

    // state register: records the class of the access accepted at this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tgt_q     <= TG_CACHE;
            rsel_q    <= RG_CTRL;
            fwd_addr  <= '0;
            fwd_wdata <= '0;
            fwd_write <= 1'b0;
        end else begin
            state  <= dec.kind;
            tgt_q  <= dec.tgt;
            rsel_q <= dec.rsel;
            if (dec.kind == ST_ROUTE) begin
                fwd_addr  <= req_addr;
                fwd_wdata <= req_wdata;
                fwd_write <= req_write;
            end
        end
    end

    // outputs decoded from the recorded state
    always_comb begin
        rsp_valid = 1'b1;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        tgt_sel   = '0;
        unique case (state)
            ST_IDLE:  rsp_valid = 1'b0;
            ST_ROUTE: tgt_sel   = N_TGT'(1) << tgt_q;
            ST_REGRD: begin
                unique case (rsel_q)
                    RG_CTRL: rsp_rdata = ctrl_rd;
                    RG_ICFG: rsp_rdata = cfg_w[0];
                    RG_DCFG: rsp_rdata = cfg_w[1];
                    default: rsp_rdata = '0;
                endcase
            end
            ST_REGWR: rsp_err   = 1'b0;
            ST_FLUSH: rsp_err   = 1'b0;
            ST_FAULT: rsp_err   = 1'b1;
            default:  rsp_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/asi_ctl_chk.sv
`timescale 1ns/1ps
module asi_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [7:0]  req_asi,
    input logic [31:0] req_addr,
    input logic        req_write,
    input logic        flush_all,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic [6:0]  tgt_sel,
    input logic        flush_ic,
    input logic        flush_dc,
    input logic [1:0]  ic_mode,
    input logic [1:0]  dc_mode
);
    AST_CACHE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_asi >= 8'h08 && req_asi <= 8'h0B) |-> tgt_sel == 7'b0000001); // R1
    AST_XLAT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_asi == 8'h19) |-> tgt_sel == 7'b1000000 && !rsp_err); // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> $stable(ic_mode) && $stable(dc_mode)); // R3
    AST_CTRL_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && req_asi == 8'h02 && req_addr[7:0] == 8'h00)
            |-> rsp_valid && rsp_rdata[22:21] == 2'b00); // R4
    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ic || flush_dc) |-> $past(req_valid) || $past(flush_all)); // R4
    AST_IFLUSH_ID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && req_asi == 8'h15) |-> flush_ic && tgt_sel == 7'b0); // R5
    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_all) |-> flush_ic && flush_dc); // R6
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> tgt_sel == 7'b0 && rsp_rdata == 32'h0); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !rsp_valid && tgt_sel == 7'b0); // R11
endmodule

bind asi_ctl_top asi_ctl_chk u_chk (.*);

// File: tb/sim_asi_ctl_top.sv
`timescale 1ns/1ps
module sim_asi_ctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_asi = '0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        flush_all = 1'b0;
    logic        rsp_valid, rsp_err, fwd_write, flush_ic, flush_dc, snoop_en, burst_en;
    logic [31:0] rsp_rdata, fwd_addr, fwd_wdata;
    logic [6:0]  tgt_sel;
    logic [1:0]  ic_mode, dc_mode;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    asi_ctl_top u0 (.*);

    // configuration words computed by weighted sums of the R7 fields
    localparam logic [31:0] EXP_ICFG = 32'(1*(2**31) + 1*(2**28) + 0*(2**27) + 1*(2**24)
                                     + 2*(2**20) + 0*(2**19) + 3*(2**16) + 0*(2**12)
                                     + 0*(2**4) + 1*(2**3));
    localparam logic [31:0] EXP_DCFG = 32'(0*(2**31) + 3*(2**28) + 1*(2**27) + 3*(2**24)
                                     + 4*(2**20) + 1*(2**19) + 2*(2**16) + 3*(2**12)
                                     + 142*(2**4) + 1*(2**3));
    localparam logic [31:0] CTRL_KEEP = 32'h0081_000F;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] asi, input logic [31:0] addr,
                         input logic wr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_asi = asi; req_addr = addr;
        req_write = wr; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // expected {err, flush_ic, flush_dc, tgt_sel[6:0]} from R1, R2, R5, R7, R8
    function automatic logic [9:0] expect_cls(input logic [7:0] asi,
                                              input logic [7:0] ofs, input logic wr);
        logic [9:0] e = '0;
        if (asi >= 8'h08 && asi <= 8'h0B) e[0] = 1'b1;
        else if (asi == 8'h01) e[1] = 1'b1;
        else if (asi >= 8'h0C && asi <= 8'h0F) e[asi - 8'h0A] = 1'b1;
        else if (asi == 8'h19) e[6] = 1'b1;
        else if (asi == 8'h02) e[9] = !(ofs == 8'h00 || ofs == 8'h08 || ofs == 8'h0C);
        else if (asi == 8'h15) begin e[8] = wr; e[9] = !wr; end
        else if (asi == 8'h16) begin e[7] = wr; e[9] = !wr; end
        else e[9] = 1'b1;
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check({rsp_valid, rsp_err, tgt_sel, flush_ic, flush_dc} == '0, "R9 outputs",
              32'({rsp_valid, rsp_err, tgt_sel, flush_ic, flush_dc}), 32'h0);
        check({ic_mode, dc_mode, snoop_en, burst_en} == '0, "R9 modes",
              32'({ic_mode, dc_mode, snoop_en, burst_en}), 32'h0);
        issue(8'h02, 32'h0, 1'b0, 32'h0);
        check(rsp_rdata == 32'h0, "R9 ctrl reset value", rsp_rdata, 32'h0);

        // R1 R2 R5 R8 sweep over every identifier, read and write
        for (int w = 0; w < 2; w++) begin
            for (int a = 0; a < 256; a++) begin
                logic [9:0] e, act;
                issue(8'(a), 32'h0000_0000, 1'(w), 32'h0);
                e = expect_cls(8'(a), 8'h00, 1'(w));
                act = {rsp_err, flush_ic, flush_dc, tgt_sel};
                check(act == e && rsp_valid, "R1/R2/R5/R8 identifier sweep",
                      32'({a[7:0], 1'(w), act}), 32'({a[7:0], 1'(w), e}));
            end
        end

        // R7 R8 offset sweep under the register identifier
        for (int o = 0; o < 256; o++) begin
            logic [9:0] e;
            logic [31:0] exp_d;
            issue(8'h02, 32'hABCD_EF00 | 32'(o), 1'b0, 32'h0);
            e = expect_cls(8'h02, 8'(o), 1'b0);
            exp_d = (o == 8) ? EXP_ICFG : (o == 12) ? EXP_DCFG : 32'h0;
            check(rsp_err == e[9] && rsp_rdata == exp_d, "R7/R8 register offset sweep",
                  rsp_rdata, exp_d);
        end

        // R3 R4 control patterns
        begin
            logic [31:0] pats [3] = '{32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h5555_5555};
            foreach (pats[i]) begin
                issue(8'h02, 32'h0, 1'b1, pats[i]);
                check(flush_ic == pats[i][21] && flush_dc == pats[i][22] && !rsp_err,
                      "R4 flush pulse from control bits",
                      32'({flush_ic, flush_dc}), 32'({pats[i][21], pats[i][22]}));
                check(ic_mode == pats[i][1:0] && dc_mode == pats[i][3:2]
                      && snoop_en == pats[i][23] && burst_en == pats[i][16],
                      "R3 mode outputs", 32'({snoop_en, burst_en, dc_mode, ic_mode}),
                      32'({pats[i][23], pats[i][16], pats[i][3:0]}));
                @(negedge clk);
                check(!flush_ic && !flush_dc, "R4 pulse lasts one cycle",
                      32'({flush_ic, flush_dc}), 32'h0);
                issue(8'h02, 32'h0, 1'b0, 32'h0);
                check(rsp_rdata == (pats[i] & CTRL_KEEP), "R3/R4 control read-back",
                      rsp_rdata, pats[i] & CTRL_KEEP);
            end
        end

        // R8 undecoded write leaves control register intact
        issue(8'h03, 32'h0, 1'b1, 32'hFFFF_FFFF);
        check(rsp_err && tgt_sel == 0 && !flush_ic && !flush_dc, "R8 undecoded write",
              32'({rsp_err, tgt_sel}), 32'h80);
        issue(8'h02, 32'h4, 1'b1, 32'hFFFF_FFFF);
        check(rsp_err, "R8 reserved offset write", 32'(rsp_err), 32'h1);
        issue(8'h02, 32'h0, 1'b0, 32'h0);
        check(rsp_rdata == 32'h0001_0005 && ic_mode == 2'b01 && dc_mode == 2'b01,
              "R8 no state change", rsp_rdata, 32'h0001_0005);

        // R7 configuration writes ignored
        issue(8'h02, 32'h8, 1'b1, 32'h0);
        check(!rsp_err && rsp_valid, "R7 config write accepted", 32'(rsp_err), 32'h0);
        issue(8'h02, 32'h8, 1'b0, 32'h0);
        check(rsp_rdata == EXP_ICFG, "R7 icfg unchanged", rsp_rdata, EXP_ICFG);
        issue(8'h02, 32'hC, 1'b1, 32'h0);
        issue(8'h02, 32'hC, 1'b0, 32'h0);
        check(rsp_rdata == EXP_DCFG, "R7 dcfg unchanged", rsp_rdata, EXP_DCFG);

        // R10 forwarded fields
        issue(8'h0A, 32'h1234_5678, 1'b1, 32'hCAFE_F00D);
        check(fwd_addr == 32'h1234_5678 && fwd_wdata == 32'hCAFE_F00D && fwd_write
              && tgt_sel == 7'b0000001, "R10 forwarded fields", fwd_addr, 32'h1234_5678);

        // R11 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_asi = 8'h19; req_addr = 32'h0000_0300; req_write = 1'b0;
        @(negedge clk);
        check(tgt_sel == 7'b1000000 && fwd_addr == 32'h300, "R11 first of pair",
              32'(tgt_sel), 32'h40);
        req_asi = 8'h0E; req_addr = 32'h0000_0040; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(tgt_sel == 7'b0010000 && fwd_addr == 32'h40 && fwd_write,
              "R11 second of pair", 32'(tgt_sel), 32'h10);
        @(negedge clk);
        check(!rsp_valid && tgt_sel == 0, "R11 idle after pair", 32'(rsp_valid), 32'h0);

        // R6 flush-instruction input
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        check(flush_ic && flush_dc && !rsp_valid, "R6 flush both",
              32'({flush_ic, flush_dc, rsp_valid}), 32'h6);
        @(negedge clk);
        check(!flush_ic && !flush_dc, "R6 pulse ends", 32'({flush_ic, flush_dc}), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule